// File: doc/BRIEF.md
# Piggyback Secondary Bus Master

This block is an extra master for a processor memory bus with 16 address lines and 8 data lines. It never opens a bus hold of its own. It waits until a graphics engine has already asked the processor to let go of the bus. It then adds its own request to the merged request line. When the graphics engine drops its request, the processor stays off the bus, and this block takes ownership for exactly one byte access.

A local controller sends single-byte read or write commands over a valid/ready command stream. It gets back one response per command over a valid/ready response stream. The response carries the byte read, or a write flag. A command that arrives while the graphics engine is not requesting the bus stays pending until the next graphics hold begins.

During an access, the block loads the address into external byte-wide latches, low byte first. It then enables the latch outputs onto the address bus and strobes active-low memory request together with read or write. I/O request is never used. Any byte of the processor's memory can be reached. A controller can therefore read a fixed region out periodically and write it back at start-up.

High impedance is realised by output enables that feed the pad buffers:
- `ctl_oe` covers the four strobes.
- `dat_oe` covers the data bus.
- `addr_oe_n` covers the latch outputs.

Top module: `bus_piggyback_master`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. A command is taken on the first cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low on the cycle after that. The command fields are `cmd_write` (1 = write, 0 = read), `cmd_addr` and `cmd_wdata`.
- R2: The block raises its own bus request only on a clock edge where `gfx_busreq_n` is sampled low. A command taken while `gfx_busreq_n` is high waits with the merged request high until the graphics engine requests the bus.
- R3: `cpu_busreq_n` is low whenever `gfx_busreq_n` or the block's own request is low. It stays low for the whole ownership, including after the graphics engine has released its request.
- R4: The block drives the bus (`ctl_oe` high) only after an edge where `gfx_busreq_n` is high and `cpu_busack_n` is low at the same time. While the graphics engine still holds its request, the block drives nothing.
- R5: The block presents each address byte on `lat_d`, with a one-cycle pulse on its load enable. `lat_le[0]` loads the low byte `cmd_addr[7:0]`, then `lat_le[1]` loads the high byte `cmd_addr[15:8]` on the next cycle. Only after both loads does `addr_oe_n` go low.
- R6: A read holds `mreq_n` and `rd_n` low together for `STROBE_CYC` cycles (default 3), with `wr_n` and `ioreq_n` high. `rd_n` and `wr_n` are never low together. The read byte is the value of `dat_in` on the last cycle with `rd_n` low.
- R7: A write holds `mreq_n` and `wr_n` low for `STROBE_CYC` cycles, with `rd_n` high. `dat_oe` is high, with `dat_out = cmd_wdata`, one cycle before `wr_n` falls and on the cycle after it rises.
- R8: Outside ownership, `ctl_oe` and `dat_oe` are low and `addr_oe_n` is high.
- R9: After the strobe, the block drops its request and raises `rsp_valid`. The response carries `rsp_write` and, for reads, `rsp_rdata`. The response stays valid and stable until `rsp_ready` is high, and the block is then idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready (idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Target memory address |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_rdata | output | 8 | Byte read (reads only) |
| gfx_busreq_n | input | 1 | Graphics engine bus request, active low |
| cpu_busack_n | input | 1 | Processor bus acknowledge, active low |
| cpu_busreq_n | output | 1 | Merged bus request to processor, active low |
| lat_d | output | 8 | Byte presented to the address latches |
| lat_le | output | 2 | Latch load enables, bit 0 low byte, bit 1 high byte |
| addr_oe_n | output | 1 | Latch output enable onto the address bus, active low |
| ctl_oe | output | 1 | Output enable for the strobes |
| mreq_n | output | 1 | Memory request strobe, active low |
| ioreq_n | output | 1 | I/O request strobe, held inactive |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dat_oe | output | 1 | Data bus output enable |
| dat_out | output | 8 | Data driven onto the bus |
| dat_in | input | 8 | Data read from the bus |

## Verification
The assertions assume that the processor acknowledges only while the merged request is low. They also assume that the graphics engine does not begin a new hold while this block owns the bus. Finally, they assume that a command's fields stay stable while `cmd_valid` waits for `cmd_ready`.

The bench respects these assumptions:
- Its processor model copies the merged request into the acknowledge with one cycle of lag.
- It releases the graphics request only once per access and keeps it released until the response is back.
- It holds each command stable until the handshake.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_HOOK,
    ST_LOAD,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RESP
  } bpm_state_e;

  function automatic logic owns_request(bpm_state_e s);
    return (s == ST_HOOK) || (s == ST_LOAD) || (s == ST_SETUP) ||
           (s == ST_STROBE) || (s == ST_HOLD);
  endfunction

  function automatic logic owns_bus(bpm_state_e s);
    return (s == ST_LOAD) || (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/bpm_req_merge.sv
module bpm_req_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic gfx_busreq_n,
  input  logic cpu_busack_n,
  input  logic own_req_n,
  output logic cpu_busreq_n,
  output logic gfx_active,
  output logic bus_handed
);

  // Either requester low keeps the processor off the bus.
  assign cpu_busreq_n = gfx_busreq_n & own_req_n;
  assign gfx_active   = ~gfx_busreq_n;
  // Graphics engine has let go while the processor still acknowledges.
  assign bus_handed   = gfx_busreq_n & ~cpu_busack_n;

  // R2: own request only starts on an edge where the graphics request was low
  p_req_needs_gfx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_req_n) |-> $past(!gfx_busreq_n));

endmodule

// File: rtl/bpm_seq.sv
module bpm_seq
  import bpm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int N_LATCH    = 2,
  parameter int STROBE_CYC = 3,
  localparam int LIDX_W    = (N_LATCH > 1) ? $clog2(N_LATCH) : 1,
  localparam int CNT_W     = $clog2(STROBE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              gfx_active,
  input  logic              bus_handed,
  input  logic [DATA_W-1:0] dat_in,
  output logic              own_req_n,
  output bpm_state_e        state,
  output logic [LIDX_W-1:0] lidx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_write
);

  localparam logic [LIDX_W-1:0] LIDX_LAST = LIDX_W'(N_LATCH - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STROBE_CYC - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lidx      <= '0;
      cnt       <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            cur_addr  <= cmd_addr;
            cur_wdata <= cmd_wdata;
            cur_write <= cmd_write;
            state     <= gfx_active ? ST_HOOK : ST_PEND;
          end
        end
        ST_PEND: begin
          if (gfx_active) state <= ST_HOOK;
        end
        ST_HOOK: begin
          if (bus_handed) begin
            state <= ST_LOAD;
            lidx  <= '0;
          end
        end
        ST_LOAD: begin
          if (lidx == LIDX_LAST) state <= ST_SETUP;
          else                   lidx  <= lidx + 1'b1;
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt   <= CNT_LAST;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            if (!cur_write) rdata_q <= dat_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: state <= ST_RESP;
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_write = cur_write;
  assign rsp_rdata = rdata_q;
  assign own_req_n = ~owns_request(state);

  // R1: a taken command closes the command port on the next cycle
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R4: ownership starts only after the hand-over was seen
  p_grant_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_HOOK) |-> $past(bus_handed && !gfx_active));

  // R9: a stalled response holds its contents
  p_rsp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_write)));

endmodule

// File: rtl/bpm_pins.sv
module bpm_pins
  import bpm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int N_LATCH  = 2,
  localparam int LIDX_W  = (N_LATCH > 1) ? $clog2(N_LATCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bpm_state_e         state,
  input  logic [LIDX_W-1:0]  lidx,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [DATA_W-1:0]  cur_wdata,
  input  logic               cur_write,
  output logic [DATA_W-1:0]  lat_d,
  output logic [N_LATCH-1:0] lat_le,
  output logic               addr_oe_n,
  output logic               ctl_oe,
  output logic               mreq_n,
  output logic               ioreq_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic               dat_oe,
  output logic [DATA_W-1:0]  dat_out
);

  logic [DATA_W-1:0] slice [N_LATCH];
  logic              access_win;
  logic              strobing;

  genvar g;
  generate
    for (g = 0; g < N_LATCH; g++) begin : g_latch
      assign slice[g]  = cur_addr[g*DATA_W +: DATA_W];
      assign lat_le[g] = (state == ST_LOAD) && (lidx == LIDX_W'(g));
      if (g > 0) begin : g_order
        // R5: each latch loads right after the one below it
        p_latch_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
          lat_le[g] |-> $past(lat_le[g-1]));
      end
    end
  endgenerate

  assign lat_d      = slice[lidx];
  assign access_win = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign strobing   = (state == ST_STROBE);

  assign ctl_oe    = owns_bus(state);
  assign addr_oe_n = ~access_win;
  assign mreq_n    = ~strobing;
  assign rd_n      = ~(strobing && !cur_write);
  assign wr_n      = ~(strobing && cur_write);
  assign ioreq_n   = 1'b1;
  assign dat_oe    = access_win && cur_write;
  assign dat_out   = cur_wdata;

  // R6: never read and write at once, and both only with memory request
  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rd_n, ~wr_n}));
  p_dir_needs_mreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !mreq_n);

  // R7: write data set up before and held after the write strobe
  p_wr_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(dat_oe));
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> dat_oe);

  // R8: nothing is driven outside ownership
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> (!dat_oe && addr_oe_n));

endmodule

// File: rtl/bus_piggyback_master.sv
module bus_piggyback_master
  import bpm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 3,
  localparam int N_LATCH   = ADDR_W / DATA_W,
  localparam int LIDX_W    = (N_LATCH > 1) ? $clog2(N_LATCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_write,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               gfx_busreq_n,
  input  logic               cpu_busack_n,
  output logic               cpu_busreq_n,
  output logic [DATA_W-1:0]  lat_d,
  output logic [N_LATCH-1:0] lat_le,
  output logic               addr_oe_n,
  output logic               ctl_oe,
  output logic               mreq_n,
  output logic               ioreq_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic               dat_oe,
  output logic [DATA_W-1:0]  dat_out,
  input  logic [DATA_W-1:0]  dat_in
);

  logic              own_req_n;
  logic              gfx_active;
  logic              bus_handed;
  bpm_state_e        state;
  logic [LIDX_W-1:0] lidx;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;

  bpm_req_merge u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .gfx_busreq_n (gfx_busreq_n),
    .cpu_busack_n (cpu_busack_n),
    .own_req_n    (own_req_n),
    .cpu_busreq_n (cpu_busreq_n),
    .gfx_active   (gfx_active),
    .bus_handed   (bus_handed)
  );

  bpm_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .N_LATCH    (N_LATCH),
    .STROBE_CYC (STROBE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .cmd_ready  (cmd_ready),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_write  (rsp_write),
    .rsp_rdata  (rsp_rdata),
    .gfx_active (gfx_active),
    .bus_handed (bus_handed),
    .dat_in     (dat_in),
    .own_req_n  (own_req_n),
    .state      (state),
    .lidx       (lidx),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .cur_write  (cur_write)
  );

  bpm_pins #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_LATCH (N_LATCH)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .lidx      (lidx),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .cur_write (cur_write),
    .lat_d     (lat_d),
    .lat_le    (lat_le),
    .addr_oe_n (addr_oe_n),
    .ctl_oe    (ctl_oe),
    .mreq_n    (mreq_n),
    .ioreq_n   (ioreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dat_oe    (dat_oe),
    .dat_out   (dat_out)
  );

  // R3: while driving the bus the merged request keeps the processor away
  p_hold_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> !cpu_busreq_n);

endmodule

// File: tb/bus_piggyback_master_test.sv
module bus_piggyback_master_test;
  localparam int SC = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_write, rsp_valid, rsp_ready, rsp_write;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_wdata, rsp_rdata, lat_d, dat_out, dat_in;
  logic        gfx_busreq_n, cpu_busack_n, cpu_busreq_n, addr_oe_n, ctl_oe;
  logic        mreq_n, ioreq_n, rd_n, wr_n, dat_oe;
  logic [1:0]  lat_le;

  bus_piggyback_master #(.STROBE_CYC(SC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .gfx_busreq_n(gfx_busreq_n), .cpu_busack_n(cpu_busack_n),
    .cpu_busreq_n(cpu_busreq_n), .lat_d(lat_d), .lat_le(lat_le), .addr_oe_n(addr_oe_n),
    .ctl_oe(ctl_oe), .mreq_n(mreq_n), .ioreq_n(ioreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .dat_oe(dat_oe), .dat_out(dat_out), .dat_in(dat_in)
  );

  // Processor model: acknowledge follows the merged request one cycle later.
  always @(posedge clk) begin
    if (!rst_n) cpu_busack_n <= 1'b1;
    else        cpu_busack_n <= cpu_busreq_n;
  end

  // External address latches and bus with pull-ups.
  logic [7:0]  lq0, lq1;
  logic [15:0] abus;
  logic        mreq_e, rd_e, wr_e, io_e;
  logic [7:0]  ram [256];

  always @(posedge clk) begin
    if (lat_le[0]) lq0 <= lat_d;
    if (lat_le[1]) lq1 <= lat_d;
  end
  assign abus   = addr_oe_n ? 16'hFFFF : {lq1, lq0};
  assign mreq_e = ctl_oe ? mreq_n  : 1'b1;
  assign rd_e   = ctl_oe ? rd_n    : 1'b1;
  assign wr_e   = ctl_oe ? wr_n    : 1'b1;
  assign io_e   = ctl_oe ? ioreq_n : 1'b1;
  assign dat_in = (!mreq_e && !rd_e) ? ram[abus[7:0]] : 8'hEE;

  always @(posedge clk) begin
    if (!mreq_e && !wr_e && dat_oe) ram[abus[7:0]] <= dat_out;
  end

  // Protocol monitor, sampled at the falling edge.
  int          strobe_cnt, lo_cnt, hi_cnt;
  bit          rd_seen, wr_seen, io_seen, both_seen, bad_hold, bad_grant, bad_fresh;
  bit          order_bad, bad_quiet, setup_ok, hold_ok;
  logic [15:0] cap_addr;
  logic        p_oe, p_gfx, p_ack, p_req, p_wr, p_doe, p_le0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ctl_oe && cpu_busreq_n) bad_hold = 1'b1;
      if (ctl_oe && !p_oe && !(p_gfx && !p_ack)) bad_grant = 1'b1;
      if (p_req && !cpu_busreq_n && gfx_busreq_n) bad_fresh = 1'b1;
      if (!mreq_e) begin
        strobe_cnt++;
        cap_addr = abus;
      end
      if (!rd_e) rd_seen = 1'b1;
      if (!wr_e) wr_seen = 1'b1;
      if (!io_e) io_seen = 1'b1;
      if (!rd_e && !wr_e) both_seen = 1'b1;
      if (!wr_e && p_wr)  setup_ok = p_doe;
      if (wr_e && !p_wr)  hold_ok  = dat_oe;
      if (lat_le[0]) begin
        lo_cnt++;
        if (lat_d != cmd_addr[7:0]) order_bad = 1'b1;
      end
      if (lat_le[1]) begin
        hi_cnt++;
        if (!p_le0 || lat_d != cmd_addr[15:8]) order_bad = 1'b1;
      end
      if (!ctl_oe && (dat_oe || !addr_oe_n)) bad_quiet = 1'b1;
    end
    p_oe = ctl_oe; p_gfx = gfx_busreq_n; p_ack = cpu_busack_n; p_req = cpu_busreq_n;
    p_wr = wr_e; p_doe = dat_oe; p_le0 = lat_le[0];
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_mon();
    strobe_cnt = 0; lo_cnt = 0; hi_cnt = 0; rd_seen = 0; wr_seen = 0; io_seen = 0;
    both_seen = 0; bad_hold = 0; bad_grant = 0; bad_fresh = 0; order_bad = 0;
    bad_quiet = 0; setup_ok = 0; hold_ok = 0; cap_addr = 16'h0;
  endtask

  // One complete access with all protocol checks.
  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input bit gfx_early, input bit stall, output logic [7:0] rd);
    logic [7:0] held;
    int k;
    clear_mon();
    rsp_ready = !stall;
    if (gfx_early) begin
      gfx_busreq_n = 1'b0;
      step(2);
    end
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    step(1);
    chk(!cmd_ready, "R1 command taken, port closed", cmd_ready, 0);
    cmd_valid = 1'b0;
    if (!gfx_early) begin
      step(4);
      chk(cpu_busreq_n && !ctl_oe, "R2 pending without graphics request", cpu_busreq_n, 1);
      gfx_busreq_n = 1'b0;
      step(1);
    end
    step(3);
    chk(!ctl_oe && addr_oe_n && !dat_oe, "R4 no drive while graphics holds", ctl_oe, 0);
    gfx_busreq_n = 1'b1;
    step(1);
    chk(!cpu_busreq_n, "R3 request kept after graphics release", cpu_busreq_n, 0);
    k = 0;
    while (!rsp_valid && k < 40) begin
      step(1);
      k++;
    end
    chk(rsp_valid, "R9 response raised", rsp_valid, 1);
    chk(rsp_write == w, "R9 response kind", rsp_write, w);
    rd = rsp_rdata;
    if (stall) begin
      held = rsp_rdata;
      step(5);
      chk(rsp_valid && rsp_rdata == held && !cmd_ready, "R9 back-pressure hold",
          rsp_rdata, held);
      rsp_ready = 1'b1;
    end
    step(1);
    chk(!rsp_valid && cmd_ready && cpu_busreq_n && !ctl_oe, "R9 released and idle",
        {rsp_valid, cmd_ready, cpu_busreq_n, ctl_oe}, 4'b0110);
    chk(strobe_cnt == SC, "R6 strobe length", strobe_cnt, SC);
    chk(cap_addr == a, "R5 address on bus", cap_addr, a);
    chk(lo_cnt == 1 && hi_cnt == 1 && !order_bad, "R5 latch load order",
        {lo_cnt[3:0], hi_cnt[3:0], 3'b0, order_bad}, 9'h110);
    chk(!io_seen && !both_seen, "R6 no ioreq, one direction", {io_seen, both_seen}, 0);
    if (w) chk(wr_seen && !rd_seen && setup_ok && hold_ok, "R7 write strobe and data window",
               {wr_seen, rd_seen, setup_ok, hold_ok}, 4'b1011);
    else   chk(rd_seen && !wr_seen, "R6 read strobe only", {rd_seen, wr_seen}, 2'b10);
    chk(!bad_hold, "R3 merged request during ownership", bad_hold, 0);
    chk(!bad_grant, "R4 drive start after hand-over", bad_grant, 0);
    chk(!bad_fresh, "R2 no fresh request", bad_fresh, 0);
    chk(!bad_quiet, "R8 undriven outside ownership", bad_quiet, 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready && !rsp_valid && cpu_busreq_n, "R1 reset idle",
        {cmd_ready, rsp_valid, cpu_busreq_n}, 3'b101);
    chk(!ctl_oe && !dat_oe && addr_oe_n && lat_le == 2'b00, "R8 reset undriven",
        {ctl_oe, dat_oe, addr_oe_n}, 3'b001);
  endtask

  task automatic t_write_idle_start();
    logic [7:0] r;
    access(1'b1, 16'h1234, 8'h5A, 1'b0, 1'b0, r);
    chk(ram[8'h34] == 8'h5A, "R7 byte written", ram[8'h34], 8'h5A);
  endtask

  task automatic t_read_back();
    logic [7:0] r;
    access(1'b0, 16'h1234, 8'h00, 1'b0, 1'b0, r);
    chk(r == 8'h5A, "R6 read returns written byte", r, 8'h5A);
  endtask

  task automatic t_read_gfx_early();
    logic [7:0] r;
    ram[8'hFF] = 8'hC3;
    access(1'b0, 16'hFFFF, 8'h00, 1'b1, 1'b0, r);
    chk(r == 8'hC3, "R2 read with graphics already holding", r, 8'hC3);
  endtask

  task automatic t_backpressure();
    logic [7:0] r;
    ram[8'hA5] = 8'h3C;
    access(1'b0, 16'h5AA5, 8'h00, 1'b0, 1'b1, r);
    chk(r == 8'h3C, "R9 stalled read data", r, 8'h3C);
  endtask

  task automatic t_write_zero_addr();
    logic [7:0] r;
    access(1'b1, 16'h0000, 8'hFF, 1'b1, 1'b0, r);
    chk(ram[8'h00] == 8'hFF, "R7 write at lowest address", ram[8'h00], 8'hFF);
    access(1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, r);
    chk(r == 8'hFF, "R6 read at lowest address", r, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = 16'h0;
    cmd_wdata = 8'h0; rsp_ready = 1'b1; gfx_busreq_n = 1'b1;
    clear_mon();
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_write_idle_start();
    t_read_back();
    t_read_gfx_early();
    t_backpressure();
    t_write_zero_addr();
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule